// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Simulation Engine

This block grades a test vector against a group of single stuck-at faults at once. A small combinational netlist of two-input AND, two-input OR and inverter cells is loaded into a gate table. Every circuit line is held as a W-bit word. Lane 0 of each word is the fault-free machine, and each of lanes 1 to W-1 is a copy of the circuit that carries one injected fault. Per-line force-to-0 and force-to-1 masks pick which lanes are stuck and at which value.

A start pulse latches one primary-input vector and copies each input bit into every lane. The engine then walks the gate table, one entry per clock, in index order. Each entry computes its output word with bitwise logic and then applies the stuck masks of that output line. After the last entry it compares every primary-output word against its own lane 0. Lanes that differ, and that were not already caught on an earlier vector of the pass, are reported in a one-cycle done pulse. A running detected vector records which faults have been dropped. A clear request empties that vector and the masks, so the next group of W-1 faults can be loaded.

Top module: `fsim_engine`

## Requirements
- R1: Lane 0 is always fault-free. Bit 0 of any written force mask is discarded, and `newly_det[0]` and `cum_det[0]` are never set.
- R2: Gate op encoding is 2'b00 skip (no line written), 2'b01 AND of in0 and in1, 2'b10 OR of in0 and in1, and 2'b11 NOT of in0. Each op works bitwise over whole words.
- R3: When a line word is written, bit k is forced to 1 if force1 bit k is set. Otherwise it is forced to 0 if force0 bit k is set. Force1 wins when both bits are set. This applies to primary-input lines when a vector is loaded and to gate outputs when they are written.
- R4: A lane counts as detected for a vector if, at any primary output, its bit differs from the lane 0 bit. The primary outputs are the top NUM_PO lines, NUM_LINES-NUM_PO up to NUM_LINES-1.
- R5: `newly_det` reports only lanes that are not already set in `cum_det`. `cum_det` takes the OR of every `newly_det` and only clears through R9 or reset.
- R6: At start, lines 0 to NUM_PI-1 take `pi_vec` bit l copied into every lane, and all other lines take zero, before the masks are applied. Table entries are evaluated in ascending index, so an entry reads the lines written by lower entries of the same vector.
- R7: A start accepted at a clock edge gives `done` high for exactly one cycle, NUM_GATES+1 edges later. `newly_det` is zero whenever `done` is low.
- R8: `busy` is high from the edge that accepts start until the done edge. While busy, start, clear_pass, gate writes and mask writes have no effect.
- R9: clear_pass, taken while idle with no start, zeroes `cum_det` and all force masks and leaves the gate table unchanged. A start in the same cycle takes precedence.
- R10: After reset `busy`, `done`, `newly_det` and `cum_det` are zero, every table entry is skip, and all masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_gate_we | input | 1 | Write one gate table entry |
| cfg_gate_idx | input | GATE_AW | Table entry index |
| cfg_gate_op | input | 2 | Gate op code (R2) |
| cfg_gate_in0 | input | LINE_AW | First source line |
| cfg_gate_in1 | input | LINE_AW | Second source line |
| cfg_gate_out | input | LINE_AW | Destination line |
| cfg_mask_we | input | 1 | Write the force masks of one line |
| cfg_mask_line | input | LINE_AW | Line whose masks are written |
| cfg_mask_f0 | input | W | Force-to-0 lanes |
| cfg_mask_f1 | input | W | Force-to-1 lanes |
| clear_pass | input | 1 | Start a new fault group |
| start | input | 1 | Latch `pi_vec` and evaluate |
| pi_vec | input | NUM_PI | Primary-input vector |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle result strobe |
| newly_det | output | W | Lanes first caught by this vector |
| cum_det | output | W | Lanes caught so far in this pass |

## Verification
The bench drives a loaded netlist with a reference model that computes each lane one bit at a time. It targets several mistakes. A line stuck both ways must resolve to 1, and a design with the wrong priority would report the wrong lane set. A mask write with bit 0 set must not corrupt the good machine, or every lane would look detected. A later table entry reads and then overwrites a primary output, so an engine that evaluated out of order or read stale words would differ. Starts, clears and writes issued while busy must change nothing, and repeated vectors must not report a dropped lane a second time.

// File: rtl/fsim_pkg.sv
package fsim_pkg;

   typedef enum logic [1:0] {
      G_SKIP = 2'b00,
      G_AND  = 2'b01,
      G_OR   = 2'b10,
      G_NOT  = 2'b11
   } gate_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_CMP  = 2'b10
   } eng_state_e;

endpackage

// File: rtl/fsim_gate_table.sv
module fsim_gate_table #(
   parameter int NUM_GATES = 8,
   parameter int LINE_AW   = 4,
   parameter int GATE_AW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [GATE_AW-1:0] waddr,
   input  logic [1:0]         wop,
   input  logic [LINE_AW-1:0] win0,
   input  logic [LINE_AW-1:0] win1,
   input  logic [LINE_AW-1:0] wout,
   input  logic [GATE_AW-1:0] raddr,
   output logic [1:0]         rop,
   output logic [LINE_AW-1:0] rin0,
   output logic [LINE_AW-1:0] rin1,
   output logic [LINE_AW-1:0] rout
);
   logic [NUM_GATES-1:0][1:0]         op_q;
   logic [NUM_GATES-1:0][LINE_AW-1:0] in0_q;
   logic [NUM_GATES-1:0][LINE_AW-1:0] in1_q;
   logic [NUM_GATES-1:0][LINE_AW-1:0] out_q;

   for (genvar g = 0; g < NUM_GATES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            op_q[g]  <= 2'b00;
            in0_q[g] <= '0;
            in1_q[g] <= '0;
            out_q[g] <= '0;
         end else if (we && (waddr == GATE_AW'(g))) begin
            op_q[g]  <= wop;
            in0_q[g] <= win0;
            in1_q[g] <= win1;
            out_q[g] <= wout;
         end
      end
   end

   assign rop  = op_q[raddr];
   assign rin0 = in0_q[raddr];
   assign rin1 = in1_q[raddr];
   assign rout = out_q[raddr];
endmodule

// File: rtl/fsim_fault_masks.sv
module fsim_fault_masks #(
   parameter int W         = 8,
   parameter int NUM_LINES = 16,
   parameter int LINE_AW   = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clr,
   input  logic                            we,
   input  logic [LINE_AW-1:0]              wline,
   input  logic [W-1:0]                    wf0,
   input  logic [W-1:0]                    wf1,
   output logic [NUM_LINES-1:0][W-1:0]     f0,
   output logic [NUM_LINES-1:0][W-1:0]     f1
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f0[l] <= '0;
            f1[l] <= '0;
         end else if (clr) begin
            f0[l] <= '0;
            f1[l] <= '0;
         end else if (we && (wline == LINE_AW'(l))) begin
            f0[l] <= {wf0[W-1:1], 1'b0};
            f1[l] <= {wf1[W-1:1], 1'b0};
         end
      end
   end
endmodule

// File: rtl/fsim_lane_alu.sv
module fsim_lane_alu
   import fsim_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] f0,
   input  logic [W-1:0] f1,
   output logic [W-1:0] y
);
   logic [W-1:0] raw;

   always_comb begin
      unique case (gate_op_e'(op))
         G_AND:   raw = a & b;
         G_OR:    raw = a | b;
         G_NOT:   raw = ~a;
         default: raw = a;
      endcase
      y = (raw & ~f0) | f1;
   end
endmodule

// File: rtl/fsim_detect.sv
module fsim_detect #(
   parameter int W      = 8,
   parameter int NUM_PO = 2
) (
   input  logic [NUM_PO-1:0][W-1:0] po_words,
   input  logic [W-1:0]             cum,
   output logic [W-1:0]             newly
);
   logic [NUM_PO-1:0][W-1:0] diff;
   logic [W-1:0]             any_diff;

   for (genvar p = 0; p < NUM_PO; p++) begin : g_po
      assign diff[p] = po_words[p] ^ {W{po_words[p][0]}};
   end

   always_comb begin
      any_diff = '0;
      for (int p = 0; p < NUM_PO; p++) any_diff = any_diff | diff[p];
      newly = any_diff & ~cum & ~W'(1);
   end
endmodule

// File: rtl/fsim_engine.sv
module fsim_engine
   import fsim_pkg::*;
#(
   parameter int W         = 8,
   parameter int NUM_LINES = 16,
   parameter int NUM_GATES = 8,
   parameter int NUM_PI    = 4,
   parameter int NUM_PO    = 2,
   localparam int LINE_AW  = $clog2(NUM_LINES),
   localparam int GATE_AW  = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_gate_we,
   input  logic [GATE_AW-1:0] cfg_gate_idx,
   input  logic [1:0]         cfg_gate_op,
   input  logic [LINE_AW-1:0] cfg_gate_in0,
   input  logic [LINE_AW-1:0] cfg_gate_in1,
   input  logic [LINE_AW-1:0] cfg_gate_out,
   input  logic               cfg_mask_we,
   input  logic [LINE_AW-1:0] cfg_mask_line,
   input  logic [W-1:0]       cfg_mask_f0,
   input  logic [W-1:0]       cfg_mask_f1,
   input  logic               clear_pass,
   input  logic               start,
   input  logic [NUM_PI-1:0]  pi_vec,
   output logic               busy,
   output logic               done,
   output logic [W-1:0]       newly_det,
   output logic [W-1:0]       cum_det
);
   localparam int PO_BASE = NUM_LINES - NUM_PO;

   if (W < 2) begin : g_bad_w
      $error("fsim_engine: W must be at least 2");
   end
   if (NUM_GATES < 1 || NUM_GATES > 32) begin : g_bad_gates
      $error("fsim_engine: NUM_GATES must be 1..32");
   end
   if (NUM_PI < 1 || NUM_PO < 1 || NUM_PI + NUM_PO > NUM_LINES) begin : g_bad_lines
      $error("fsim_engine: inputs and outputs must fit in NUM_LINES");
   end
   if ((1 << LINE_AW) != NUM_LINES) begin : g_bad_pow2
      $error("fsim_engine: NUM_LINES must be a power of two");
   end

   eng_state_e                     state_q;
   logic [GATE_AW-1:0]             gidx_q;
   logic [NUM_LINES-1:0][W-1:0]    line_q;
   logic [NUM_LINES-1:0][W-1:0]    f0_all, f1_all;
   logic                           idle, take_start, take_cfg, take_clear;
   logic [1:0]                     rop;
   logic [LINE_AW-1:0]             rin0, rin1, rout;
   logic [W-1:0]                   alu_y, det_newly;

   assign idle       = (state_q == ST_IDLE);
   assign take_start = idle && start;
   assign take_cfg   = idle && !start;
   assign take_clear = take_cfg && clear_pass;
   assign busy       = !idle;

   fsim_gate_table #(.NUM_GATES(NUM_GATES), .LINE_AW(LINE_AW), .GATE_AW(GATE_AW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_gate_we && take_cfg), .waddr(cfg_gate_idx), .wop(cfg_gate_op),
      .win0(cfg_gate_in0), .win1(cfg_gate_in1), .wout(cfg_gate_out),
      .raddr(gidx_q), .rop(rop), .rin0(rin0), .rin1(rin1), .rout(rout)
   );

   fsim_fault_masks #(.W(W), .NUM_LINES(NUM_LINES), .LINE_AW(LINE_AW)) u_masks (
      .clk(clk), .rst_n(rst_n), .clr(take_clear),
      .we(cfg_mask_we && take_cfg), .wline(cfg_mask_line),
      .wf0(cfg_mask_f0), .wf1(cfg_mask_f1), .f0(f0_all), .f1(f1_all)
   );

   fsim_lane_alu #(.W(W)) u_alu (
      .op(rop), .a(line_q[rin0]), .b(line_q[rin1]),
      .f0(f0_all[rout]), .f1(f1_all[rout]), .y(alu_y)
   );

   fsim_detect #(.W(W), .NUM_PO(NUM_PO)) u_detect (
      .po_words(line_q[NUM_LINES-1:PO_BASE]), .cum(cum_det), .newly(det_newly)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         gidx_q    <= '0;
         line_q    <= '0;
         done      <= 1'b0;
         newly_det <= '0;
         cum_det   <= '0;
      end else begin
         done      <= 1'b0;
         newly_det <= '0;
         unique case (state_q)
            ST_IDLE: begin
               if (take_start) begin
                  for (int l = 0; l < NUM_LINES; l++) begin
                     line_q[l] <= (((l < NUM_PI) ? {W{pi_vec[l % NUM_PI]}} : {W{1'b0}})
                                   & ~f0_all[l]) | f1_all[l];
                  end
                  gidx_q  <= '0;
                  state_q <= ST_RUN;
               end else if (take_clear) begin
                  cum_det <= '0;
               end
            end
            ST_RUN: begin
               if (gate_op_e'(rop) != G_SKIP) line_q[rout] <= alu_y;
               gidx_q <= gidx_q + 1'b1;
               if (gidx_q == GATE_AW'(NUM_GATES - 1)) state_q <= ST_CMP;
            end
            default: begin
               done      <= 1'b1;
               newly_det <= det_newly;
               cum_det   <= cum_det | det_newly;
               state_q   <= ST_IDLE;
            end
         endcase
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done held"); // R7
   AST_NEWLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (newly_det == '0)) else $error("newly without done"); // R7
   AST_LANE0_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      !newly_det[0] && !cum_det[0]) else $error("lane 0 flagged"); // R1
   AST_NO_REDETECT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((newly_det & $past(cum_det)) == '0)) else $error("dropped lane reported"); // R5
   AST_CUM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((cum_det & $past(cum_det)) == $past(cum_det))) else $error("cum lost bits"); // R5
   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)) else $error("busy without start"); // R8
endmodule

// File: tb/fsim_engine_tb.sv
module fsim_engine_tb;
   localparam int W = 8, NL = 16, NG = 8, NPI = 4, NPO = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_gate_we = 0, cfg_mask_we = 0, clear_pass = 0, start = 0;
   logic [2:0] cfg_gate_idx = '0;
   logic [1:0] cfg_gate_op = '0;
   logic [3:0] cfg_gate_in0 = '0, cfg_gate_in1 = '0, cfg_gate_out = '0, cfg_mask_line = '0;
   logic [W-1:0] cfg_mask_f0 = '0, cfg_mask_f1 = '0;
   logic [NPI-1:0] pi_vec = '0;
   logic busy, done;
   logic [W-1:0] newly_det, cum_det;

   always #10 clk = ~clk;

   fsim_engine #(.W(W), .NUM_LINES(NL), .NUM_GATES(NG), .NUM_PI(NPI), .NUM_PO(NPO)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_gate_we(cfg_gate_we), .cfg_gate_idx(cfg_gate_idx),
      .cfg_gate_op(cfg_gate_op), .cfg_gate_in0(cfg_gate_in0), .cfg_gate_in1(cfg_gate_in1),
      .cfg_gate_out(cfg_gate_out), .cfg_mask_we(cfg_mask_we), .cfg_mask_line(cfg_mask_line),
      .cfg_mask_f0(cfg_mask_f0), .cfg_mask_f1(cfg_mask_f1), .clear_pass(clear_pass),
      .start(start), .pi_vec(pi_vec), .busy(busy), .done(done),
      .newly_det(newly_det), .cum_det(cum_det)
   );

   int errors = 0, checks = 0, cyc = 0;
   bit checking = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_op[NG], m_i0[NG], m_i1[NG], m_o[NG];
   logic [W-1:0] m_f0[NL], m_f1[NL];
   logic [W-1:0] m_cum, m_newly, m_pend;
   bit m_busy, m_done;
   int m_cnt;

   function automatic logic [W-1:0] model_detect(input logic [NPI-1:0] pi);
      logic [W-1:0] det = '0;
      bit po_val[W][NPO];
      for (int lane = 0; lane < W; lane++) begin
         bit v[NL];
         for (int l = 0; l < NL; l++) begin
            v[l] = (l < NPI) ? pi[l] : 1'b0;
            if (m_f1[l][lane]) v[l] = 1'b1;
            else if (m_f0[l][lane]) v[l] = 1'b0;
         end
         for (int g = 0; g < NG; g++) begin
            bit r;
            if (m_op[g] == 0) continue;
            if (m_op[g] == 1) r = v[m_i0[g]] & v[m_i1[g]];
            else if (m_op[g] == 2) r = v[m_i0[g]] | v[m_i1[g]];
            else r = !v[m_i0[g]];
            if (m_f1[m_o[g]][lane]) r = 1'b1;
            else if (m_f0[m_o[g]][lane]) r = 1'b0;
            v[m_o[g]] = r;
         end
         for (int p = 0; p < NPO; p++) po_val[lane][p] = v[NL-NPO+p];
      end
      for (int lane = 1; lane < W; lane++)
         for (int p = 0; p < NPO; p++)
            if (po_val[lane][p] != po_val[0][p]) det[lane] = 1'b1;
      return det;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
      if (!rst_n) begin
         for (int g = 0; g < NG; g++) begin m_op[g] = 0; m_i0[g] = 0; m_i1[g] = 0; m_o[g] = 0; end
         for (int l = 0; l < NL; l++) begin m_f0[l] = '0; m_f1[l] = '0; end
         m_cum = '0; m_newly = '0; m_busy = 0; m_done = 0; m_cnt = 0; m_pend = '0;
      end else if (!m_busy) begin
         m_done = 0; m_newly = '0;
         if (start) begin
            m_pend = model_detect(pi_vec) & ~m_cum;
            m_busy = 1; m_cnt = NG + 1;
         end else begin
            if (cfg_gate_we) begin
               m_op[cfg_gate_idx] = cfg_gate_op; m_i0[cfg_gate_idx] = cfg_gate_in0;
               m_i1[cfg_gate_idx] = cfg_gate_in1; m_o[cfg_gate_idx] = cfg_gate_out;
            end
            if (clear_pass) begin
               m_cum = '0;
               for (int l = 0; l < NL; l++) begin m_f0[l] = '0; m_f1[l] = '0; end
            end else if (cfg_mask_we) begin
               m_f0[cfg_mask_line] = cfg_mask_f0 & ~W'(1);
               m_f1[cfg_mask_line] = cfg_mask_f1 & ~W'(1);
            end
         end
      end else begin
         m_cnt--;
         if (m_cnt == 0) begin
            m_busy = 0; m_done = 1; m_newly = m_pend; m_cum = m_cum | m_pend;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && checking) begin
         check(busy == m_busy, "R8 busy", busy, m_busy);
         check(done == m_done, "R7 done", done, m_done);
         check(newly_det == m_newly, "R2 R3 R4 R6 newly_det", newly_det, m_newly);
         check(cum_det == m_cum, "R5 R9 cum_det", cum_det, m_cum);
         if (done) check(!newly_det[0] && !cum_det[0], "R1 lane0", {newly_det[0], cum_det[0]}, 0);
      end
   end

   task automatic put_gate(input int idx, input int op, input int a, input int b, input int o);
      @(negedge clk);
      cfg_gate_we = 1; cfg_gate_idx = idx[2:0]; cfg_gate_op = op[1:0];
      cfg_gate_in0 = a[3:0]; cfg_gate_in1 = b[3:0]; cfg_gate_out = o[3:0];
      @(negedge clk);
      cfg_gate_we = 0;
   endtask

   task automatic put_mask(input int line, input logic [W-1:0] f0, input logic [W-1:0] f1);
      @(negedge clk);
      cfg_mask_we = 1; cfg_mask_line = line[3:0]; cfg_mask_f0 = f0; cfg_mask_f1 = f1;
      @(negedge clk);
      cfg_mask_we = 0;
   endtask

   task automatic run_vec(input int v, input bit disturb);
      @(negedge clk);
      start = 1; pi_vec = v[NPI-1:0];
      @(negedge clk);
      start = 0;
      if (disturb) begin
         // R8: everything below must be ignored while busy
         start = 1; clear_pass = 1; pi_vec = ~v[NPI-1:0];
         cfg_gate_we = 1; cfg_gate_idx = 3'd0; cfg_gate_op = 2'b11;
         cfg_gate_in0 = 4'd3; cfg_gate_in1 = 4'd3; cfg_gate_out = 4'd15;
         cfg_mask_we = 1; cfg_mask_line = 4'd14; cfg_mask_f0 = 8'hFE; cfg_mask_f1 = 8'h00;
         @(negedge clk);
         start = 0; clear_pass = 0; cfg_gate_we = 0; cfg_mask_we = 0;
      end
      while (busy || done) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(!busy && !done && newly_det == 0 && cum_det == 0, "R10 reset state",
            {busy, done, newly_det, cum_det}, 0);
      checking = 1;
      put_gate(0, 1, 0, 1, 4);
      put_gate(1, 2, 2, 3, 5);
      put_gate(2, 3, 4, 4, 6);
      put_gate(3, 1, 6, 5, 14);
      put_gate(4, 2, 4, 2, 15);
      put_mask(4, 8'h02, 8'h04);
      put_mask(0, 8'h00, 8'h08);
      put_mask(5, 8'h10, 8'h00);
      put_mask(14, 8'h00, 8'h20);
      put_mask(6, 8'h40, 8'h40);
      put_mask(2, 8'h80, 8'h00);
      put_mask(3, 8'h01, 8'h01);
      run_vec(0, 0);
      run_vec(15, 1);
      for (int v = 1; v < 16; v++) run_vec(v, 0);
      @(negedge clk); clear_pass = 1;
      @(negedge clk); clear_pass = 0;
      @(negedge clk);
      check(cum_det == 0, "R9 clear", cum_det, 0);
      put_gate(5, 2, 14, 0, 14);
      put_mask(1, 8'h06, 8'h18);
      put_mask(15, 8'h60, 8'h00);
      put_mask(5, 8'h00, 8'h80);
      for (int v = 0; v < 16; v++) run_vec(v, v == 5);
      @(negedge clk); clear_pass = 1; start = 1; pi_vec = 4'h6;
      @(negedge clk); clear_pass = 0; start = 0;
      while (busy || done) @(negedge clk);
      check(busy == 0, "R9 start wins", busy, 0);
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule